// File: doc/BRIEF.md
# Serial Single-Error-Correcting Decoder for a (7,4) Cyclic Code

This block receives 7-bit words of a binary cyclic code with 4 message bits. The bits arrive one per clock, highest-order coefficient first. It returns each word with any single flipped bit put right. While a word is loading, every accepted bit is written into a 7-stage holding register and also into a 3-stage divider. The divider forms the remainder of the received polynomial modulo the generator 1 + X + X^3.

Once the seventh bit is in, the block drains the held word over seven clocks. On each drain cycle the syndrome is advanced as though a zero were divided in. A detector compares it with the single pattern that an error in the top position would leave. When the two match, the bit leaving the holding register is the faulty one: it is inverted, and the divider's feedback removes that error's contribution to the syndrome. The decoder therefore needs no table of syndromes; it needs only one comparator.

A user streams in a word with `inValid` and collects seven `outValid` cycles afterwards. The next word may begin in the cycle after the last drain cycle. While the block is draining, its input is not looked at.

Top module: `meggitt_decoder`

## Requirements
- R1: A synchronous active-high `rst` returns the block to the loading phase with zero bits accepted, and `outValid` and `corrFlag` low. This holds when it arrives part-way through a word as well; the word that follows is then decoded correctly.
- R2: On a clock edge in the loading phase, the bit on `inBit` is accepted only when `inValid` is high; cycles with `inValid` low change nothing. Received bit k is the coefficient of X^k and is presented in the order X^6 down to X^0.
- R3: In the cycle after the seventh accepted bit, `outValid` rises and stays high for exactly seven consecutive cycles. `outBit` carries the corrected coefficients X^6 down to X^0, one per cycle.
- R4: A received word that is a codeword (a multiple of 1 + X + X^3) is returned unchanged, and `corrFlag` stays low for the whole drain.
- R5: A received word that is a codeword with one bit inverted, at any of the seven positions, is returned as that codeword. `corrFlag` is high only in the drain cycle in which the repaired bit appears on `outBit`.
- R6: The syndrome is the remainder modulo g(x) = 1 + X + X^3 (generator coefficient vector 4'b1011, bit i = coefficient of X^i). The correction pattern is the remainder of X^6, which is 3'b101. A lone error on the X^6 coefficient is therefore repaired in the first drain cycle.
- R7: `inValid` and `inBit` are ignored throughout the drain phase: they neither change the word being output nor count toward the next word.
- R8: A new word may begin on the clock edge that ends the last drain cycle, so that words can follow back to back with no idle cycle.
- R9: At most one bit per word is inverted, so `corrFlag` is high in at most one cycle per drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inBit | input | 1 | Serial received bit, highest-order coefficient first |
| inValid | input | 1 | Qualifies `inBit` during the loading phase |
| outBit | output | 1 | Serial corrected bit, highest-order coefficient first |
| outValid | output | 1 | High during the seven drain cycles |
| corrFlag | output | 1 | High in the drain cycle whose output bit was inverted |

## Verification
A divider state that is off by even one tap gives a wrong syndrome. That shows up inside the same word: either a bit that should be repaired is not, or a good bit is inverted and `corrFlag` pulses at a position that does not match the injected error. A phase counter that slips shows up at once as a drain that is not seven cycles long, or as the next word decoding shifted by one position. Ignored input that leaks in during the drain corrupts the following word. Every word is therefore compared bit by bit, along with the cycle in which its flag appears, as soon as its drain completes.

// File: rtl/meggitt_pkg.sv
package meggitt_pkg;

  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeBit;   // accept a received bit this cycle
    logic firstBit;  // the accepted bit starts a new word
    logic drainBit;  // emit one corrected bit this cycle
  } strobe_t;

endpackage

// File: rtl/meggitt_syndrome.sv
module meggitt_syndrome #(
  parameter int          R        = 3,
  parameter logic [R:0]  GEN_POLY = 4'b1011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stepEn,
  input  logic         startFresh,
  input  logic         feedBit,
  output logic [R-1:0] synd
);

  logic [R-1:0] baseVal;
  logic [R-1:0] nextVal;
  logic         fbBit;

  assign baseVal = startFresh ? '0 : synd;
  assign fbBit   = baseVal[R-1];

  // Division by g(x): the constant term of g is always one
  assign nextVal[0] = feedBit ^ fbBit;

  for (genvar i = 1; i < R; i++) begin : g_tap
    if (GEN_POLY[i]) begin : g_fb
      assign nextVal[i] = baseVal[i-1] ^ fbBit;
    end else begin : g_plain
      assign nextVal[i] = baseVal[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synd <= '0;
    end else if (stepEn) begin
      synd <= nextVal;
    end
  end

endmodule

// File: rtl/meggitt_ctrl.sv
module meggitt_ctrl
  import meggitt_pkg::*;
#(
  parameter int N = 7
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobe
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_e        phase;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_LOAD;
      bitCnt <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: begin
          if (inValid) begin
            if (bitCnt == LAST) begin
              phase  <= PH_DRAIN;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        PH_DRAIN: begin
          if (bitCnt == LAST) begin
            phase  <= PH_LOAD;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: begin
          phase  <= PH_LOAD;
          bitCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.takeBit  = (phase == PH_LOAD) && inValid;
    strobe.firstBit = (phase == PH_LOAD) && inValid && (bitCnt == '0);
    strobe.drainBit = (phase == PH_DRAIN);
  end

  // R2: idle cycles during loading leave the count alone
  p_load_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && !inValid) |=> (phase == PH_LOAD && $stable(bitCnt)));

  // R3: the seventh accepted bit starts the drain
  p_enter_drain_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && inValid && bitCnt == LAST) |=> (phase == PH_DRAIN && bitCnt == '0));

  // R7: the drain advances every cycle whatever the input does
  p_drain_advance_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN && bitCnt != LAST) |=> (phase == PH_DRAIN && bitCnt == $past(bitCnt) + 1'b1));

  // R8: the drain ends after its last cycle, ready for a new word
  p_drain_end_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN && bitCnt == LAST) |=> (phase == PH_LOAD && bitCnt == '0));

endmodule

// File: rtl/meggitt_datapath.sv
module meggitt_datapath
  import meggitt_pkg::*;
#(
  parameter int          N        = 7,
  parameter int          R        = 3,
  parameter logic [R:0]  GEN_POLY = 4'b1011
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobe,
  input  logic    inBit,
  output logic    outBit,
  output logic    fixNow
);

  // Remainder of X^p modulo g(x)
  function automatic logic [R-1:0] remXpow(input int p);
    logic [R-1:0] acc;
    logic         top;
    acc    = '0;
    acc[0] = 1'b1;
    for (int j = 0; j < p; j++) begin
      top = acc[R-1];
      acc = acc << 1;
      if (top) acc = acc ^ GEN_POLY[R-1:0];
    end
    return acc;
  endfunction

  localparam logic [R-1:0] TRIGGER = remXpow(N - 1);

  logic [N-1:0] holdBuf;
  logic [R-1:0] synd;
  logic         detect;
  logic         feedBit;

  assign detect  = strobe.drainBit && (synd == TRIGGER);
  assign feedBit = strobe.takeBit ? inBit : detect;

  meggitt_syndrome #(
    .R        (R),
    .GEN_POLY (GEN_POLY)
  ) u_synd (
    .clk        (clk),
    .rst        (rst),
    .stepEn     (strobe.takeBit | strobe.drainBit),
    .startFresh (strobe.firstBit),
    .feedBit    (feedBit),
    .synd       (synd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      holdBuf <= '0;
    end else if (strobe.takeBit) begin
      holdBuf <= {holdBuf[N-2:0], inBit};
    end else if (strobe.drainBit) begin
      holdBuf <= {holdBuf[N-2:0], 1'b0};
    end
  end

  assign outBit = holdBuf[N-1] ^ detect;
  assign fixNow = detect;

  // R5: a repair removes the error from the syndrome
  p_clear_after_fix_r5: assert property (@(posedge clk) disable iff (rst)
    detect |=> (synd == '0));

  // R9: once the syndrome is clear no further bit is inverted
  p_single_fix_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.drainBit && synd == '0) |=> !detect);

  // R4: a zero syndrome never triggers a repair
  p_clean_word_r4: assert property (@(posedge clk) disable iff (rst)
    (synd == '0) |-> !detect);

endmodule

// File: rtl/meggitt_decoder.sv
module meggitt_decoder
  import meggitt_pkg::*;
#(
  parameter int          N        = 7,
  parameter int          K        = 4,
  parameter logic [N-K:0] GEN_POLY = 4'b1011
) (
  input  logic clk,
  input  logic rst,
  input  logic inBit,
  input  logic inValid,
  output logic outBit,
  output logic outValid,
  output logic corrFlag
);

  localparam int R = N - K;

  strobe_t strobe;

  meggitt_ctrl #(
    .N (N)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe)
  );

  meggitt_datapath #(
    .N        (N),
    .R        (R),
    .GEN_POLY (GEN_POLY)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inBit  (inBit),
    .outBit (outBit),
    .fixNow (corrFlag)
  );

  assign outValid = strobe.drainBit;

  // R3: a flag can only appear alongside valid output
  p_flag_in_drain_r3: assert property (@(posedge clk) disable iff (rst)
    corrFlag |-> outValid);

endmodule

// File: tb/meggitt_decoder_bench.sv
`timescale 1ns/1ps
module meggitt_decoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inBit = 1'b0;
  logic inValid = 1'b0;
  logic outBit;
  logic outValid;
  logic corrFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  meggitt_decoder u_meggitt_decoder (
    .clk      (clk),
    .rst      (rst),
    .inBit    (inBit),
    .inValid  (inValid),
    .outBit   (outBit),
    .outValid (outValid),
    .corrFlag (corrFlag)
  );

  function automatic logic [6:0] encode(input logic [3:0] msg);
    logic [6:0] cw;
    cw = '0;
    for (int i = 0; i < 4; i++)
      if (msg[i]) cw = cw ^ (7'b0001011 << i);
    return cw;
  endfunction

  function automatic logic [6:0] nearest(input logic [6:0] rx);
    logic [6:0] best;
    int         bestDist;
    best = encode(4'd0);
    bestDist = 8;
    for (int m = 0; m < 16; m++) begin
      if ($countones(encode(4'(m)) ^ rx) < bestDist) begin
        bestDist = $countones(encode(4'(m)) ^ rx);
        best = encode(4'(m));
      end
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input bit gaps);
    if (gaps && ($urandom % 3 == 0)) begin
      @(negedge clk);
      inValid = 1'b0;
      inBit = 1'($urandom);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b1;
    inBit = b;
    @(posedge clk);
  endtask

  task automatic runWord(input logic [6:0] rx, input bit gaps, input bit junk, input string tag);
    logic [6:0] gotWord;
    logic [6:0] flagMask;
    logic [6:0] expWord;
    int         validCnt;
    expWord = nearest(rx);
    // R8: no drain still running when the next word starts
    @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid before word", {6'd0, outValid}, 7'd0);
    inValid = 1'b1;
    inBit = rx[6];
    @(posedge clk);
    for (int k = 5; k >= 0; k--) sendBit(rx[k], gaps);
    gotWord = '0;
    flagMask = '0;
    validCnt = 0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      inValid = junk ? 1'($urandom) | 1'b1 : 1'b0;
      inBit = 1'($urandom);
      if (outValid) validCnt++;
      gotWord[6-k] = outBit;
      flagMask[6-k] = corrFlag;
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    check(validCnt == 7, "R3", "drain length", 7'(validCnt), 7'd7);
    check(gotWord == expWord, tag, "corrected word", gotWord, expWord);
    check(flagMask == (rx ^ expWord), tag, "flag position R9", flagMask, rx ^ expWord);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] cw;
    int         seedInit;
    seedInit = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid after reset", {6'd0, outValid}, 7'd0);
    check(corrFlag == 1'b0, "R1", "corrFlag after reset", {6'd0, corrFlag}, 7'd0);

    // R4: clean codewords
    runWord(encode(4'b1011), 1'b0, 1'b0, "R4");
    runWord(encode(4'b0000), 1'b0, 1'b0, "R4");
    runWord(encode(4'b1111), 1'b0, 1'b0, "R4");

    // R6: lone error on X^6
    runWord(7'b1000000, 1'b0, 1'b0, "R6");

    // R5: each error position
    cw = encode(4'b0110);
    for (int p = 0; p < 7; p++) runWord(cw ^ (7'd1 << p), 1'b0, 1'b0, "R5");

    // R2: gaps in inValid during loading
    runWord(encode(4'b1001) ^ 7'b0000100, 1'b1, 1'b0, "R2");
    runWord(encode(4'b0101), 1'b1, 1'b0, "R2");

    // R7: input toggling during the drain is ignored
    runWord(encode(4'b1100) ^ 7'b0010000, 1'b0, 1'b1, "R7");
    runWord(encode(4'b0011) ^ 7'b0000001, 1'b0, 1'b1, "R7");

    // R1: reset in the middle of loading
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(outValid == 1'b0, "R1", "outValid after mid-word reset", {6'd0, outValid}, 7'd0);
    runWord(encode(4'b1110) ^ 7'b0100000, 1'b0, 1'b0, "R1");

    // Random words mixed with the above
    for (int w = 0; w < 150; w++) begin
      logic [6:0] rx;
      rx = encode(4'($urandom));
      if ($urandom % 4 != 0) rx = rx ^ (7'd1 << ($urandom % 7));
      runWord(rx, 1'($urandom), 1'($urandom), "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule